// File: doc/BRIEF.md
# Exchange-Based Byte Lock Unit

This block performs an arithmetic-shift-right-by-one operation on a byte held in shared memory. It is used as a test-and-take lock primitive. A lock byte is only ever 0 (held) or 1 (free). Shifting it right moves the free bit into the carry flag and leaves zero behind. A set carry therefore tells the requesting processor that it now owns the lock.

A locked read-modify-write would tie up the memory system. The unit avoids that in the common case. It first issues an atomic exchange that stores zero and returns the previous contents. When the previous value was 0 or 1, the stored zero is already the correct shifted result, and the operation ends there. For any other value, the byte was ordinary data rather than a lock. The unit then computes the sign-preserving shift of the old value and stores it with a separate, non-interlocked write cycle.

Each operation returns the shifted byte together with carry, zero and negative flags, and ends with a one-cycle completion pulse.

Top module: `swaplock_unit`

## Requirements
- R1: After reset, `cpu_busy_o`, `cpu_done_o` and `mem_valid_o` are all 0.
- R2: A request accepted while idle causes, in the next cycle, a memory cycle with `mem_op_o` = 1 (exchange), `mem_wdata_o` = 0 and `mem_addr_o` equal to the request address. `cpu_busy_o` is high from that cycle until the done cycle inclusive.
- R3: When the exchange returns 0 or 1, no further memory cycle is issued, and the result byte is 0.
- R4: When the exchange returns any other value v, exactly one write cycle follows, with `mem_op_o` = 2 (write), the same address, and `mem_wdata_o` = v shifted right by one with bit 7 copied into itself. The result byte equals that written value.
- R5: `cpu_carry_o` equals bit 0 of the value returned by the exchange.
- R6: `cpu_zero_o` is 1 exactly when the result byte is 0. `cpu_neg_o` equals bit 7 of the result byte.
- R7: `cpu_done_o` is a single-cycle pulse in the cycle after the final memory acknowledge (`mem_valid_o` and `mem_ready_i` both high).
- R8: A request presented while the unit is busy is ignored. It causes no memory cycle and no change to the addressed byte.
- R9: While `mem_valid_o` is high and `mem_ready_i` is low, `mem_valid_o`, `mem_op_o`, `mem_addr_o` and `mem_wdata_o` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_i | input | 1 | Start an operation (sampled only when idle) |
| cpu_addr_i | input | ADDR_W | Byte address of the operand |
| cpu_busy_o | output | 1 | Operation in progress |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_result_o | output | DATA_W | Shifted byte |
| cpu_carry_o | output | 1 | Bit shifted out |
| cpu_zero_o | output | 1 | Result is zero |
| cpu_neg_o | output | 1 | Result sign bit |
| mem_valid_o | output | 1 | Memory cycle request |
| mem_op_o | output | 2 | 0 none, 1 exchange, 2 write |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Data stored by exchange or write |
| mem_ready_i | input | 1 | Memory accepts the cycle |
| mem_rdata_i | input | DATA_W | Old contents, valid with ready on an exchange |

## Verification
The assertions check the following on every cycle:
- the handshake hold rule;
- that an exchange always stores zero;
- that an exchange returning a lock value ends directly in the done pulse;
- that a write never stores zero;
- that done is a one-cycle pulse following an acknowledge;
- that busy covers done;
- that a negative result is never flagged zero.

Some behaviours can only be shown by the bench's scenarios, which use a memory model with varying latency:
- the exact shifted value and carry for each data pattern (0, 1, 2, 0x80, 0xFF and others);
- the final memory contents;
- the per-operation count of exchange and write cycles;
- that a request arriving mid-operation leaves its target byte untouched.

// File: rtl/swaplock_pkg.sv
package swaplock_pkg;
  typedef enum logic [1:0] {
    MOP_NONE  = 2'd0,
    MOP_XCHG  = 2'd1,
    MOP_WRITE = 2'd2
  } mem_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XCHG,
    ST_WRITE,
    ST_DONE
  } lock_state_e;
endpackage

// File: rtl/swaplock_alu.sv
module swaplock_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] old_val,
  output logic [DATA_W-1:0] shifted,
  output logic              carry,
  output logic              lock_like
);
  localparam int SIGN_BIT = DATA_W - 1;

  function automatic logic [DATA_W-1:0] asr1(input logic [DATA_W-1:0] v);
    return {v[SIGN_BIT], v[SIGN_BIT:1]};
  endfunction

  function automatic logic is_lock_value(input logic [DATA_W-1:0] v);
    return v[SIGN_BIT:1] == '0;
  endfunction

  always_comb begin
    shifted   = asr1(old_val);
    carry     = old_val[0];
    lock_like = is_lock_value(old_val);
  end
endmodule

// File: rtl/swaplock_flags.sv
module swaplock_flags #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] result,
  output logic              zero,
  output logic              neg
);
  function automatic logic zero_of(input logic [DATA_W-1:0] v);
    return v == '0;
  endfunction

  always_comb begin
    zero = zero_of(result);
    neg  = result[DATA_W-1];
  end
endmodule

// File: rtl/swaplock_seq.sv
module swaplock_seq
  import swaplock_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] alu_shifted,
  input  logic              alu_carry,
  input  logic              alu_lock_like,
  output logic              mem_valid,
  output logic [1:0]        mem_op,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] result,
  output logic              carry,
  output logic              done,
  output logic              busy,
  output logic              accept_ev,
  output logic              xchg_ack_ev,
  output logic              write_ack_ev
);
  lock_state_e       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] res_q;
  logic              carry_q;

  always_comb begin
    accept_ev    = (state_q == ST_IDLE) && req;
    xchg_ack_ev  = (state_q == ST_XCHG) && mem_ready;
    write_ack_ev = (state_q == ST_WRITE) && mem_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      res_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_ev) begin
          addr_q  <= req_addr;
          state_q <= ST_XCHG;
        end
        ST_XCHG: if (xchg_ack_ev) begin
          carry_q <= alu_carry;
          if (alu_lock_like) begin
            res_q   <= '0;
            state_q <= ST_DONE;
          end else begin
            res_q   <= alu_shifted;
            state_q <= ST_WRITE;
          end
        end
        ST_WRITE: if (write_ack_ev) state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_valid = (state_q == ST_XCHG) || (state_q == ST_WRITE);
    mem_addr  = addr_q;
    mem_wdata = (state_q == ST_WRITE) ? res_q : '0;
    case (state_q)
      ST_XCHG:  mem_op = MOP_XCHG;
      ST_WRITE: mem_op = MOP_WRITE;
      default:  mem_op = MOP_NONE;
    endcase
    done   = state_q == ST_DONE;
    busy   = state_q != ST_IDLE;
    result = res_q;
    carry  = carry_q;
  end
endmodule

// File: rtl/swaplock_unit.sv
module swaplock_unit #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic              cpu_busy_o,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_result_o,
  output logic              cpu_carry_o,
  output logic              cpu_zero_o,
  output logic              cpu_neg_o,
  output logic              mem_valid_o,
  output logic [1:0]        mem_op_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic [DATA_W-1:0] alu_shifted;
  logic              alu_carry;
  logic              alu_lock_like;
  logic              accept_ev;
  logic              xchg_ack_ev;
  logic              write_ack_ev;

  swaplock_alu #(.DATA_W(DATA_W)) u_alu (
    .old_val   (mem_rdata_i),
    .shifted   (alu_shifted),
    .carry     (alu_carry),
    .lock_like (alu_lock_like)
  );

  swaplock_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req           (cpu_req_i),
    .req_addr      (cpu_addr_i),
    .mem_ready     (mem_ready_i),
    .alu_shifted   (alu_shifted),
    .alu_carry     (alu_carry),
    .alu_lock_like (alu_lock_like),
    .mem_valid     (mem_valid_o),
    .mem_op        (mem_op_o),
    .mem_addr      (mem_addr_o),
    .mem_wdata     (mem_wdata_o),
    .result        (cpu_result_o),
    .carry         (cpu_carry_o),
    .done          (cpu_done_o),
    .busy          (cpu_busy_o),
    .accept_ev     (accept_ev),
    .xchg_ack_ev   (xchg_ack_ev),
    .write_ack_ev  (write_ack_ev)
  );

  swaplock_flags #(.DATA_W(DATA_W)) u_flags (
    .result (cpu_result_o),
    .zero   (cpu_zero_o),
    .neg    (cpu_neg_o)
  );
endmodule

// File: rtl/swaplock_chk.sv
module swaplock_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_busy_o,
  input logic              cpu_done_o,
  input logic              cpu_zero_o,
  input logic              cpu_neg_o,
  input logic              mem_valid_o,
  input logic [1:0]        mem_op_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ready_i,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic              xchg_ack_ev,
  input logic              write_ack_ev
);
  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_op_o)
      && $stable(mem_addr_o) && $stable(mem_wdata_o));

  // R2
  xchg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && mem_op_o == 2'd1 |-> mem_wdata_o == '0);

  // R3
  lock_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_ack_ev && mem_rdata_i[DATA_W-1:1] == '0 |=> cpu_done_o && !mem_valid_o);

  // R4
  write_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && mem_op_o == 2'd2 |-> mem_wdata_o != '0);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done_o |=> !cpu_done_o);

  // R7
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_done_o) |-> $past(xchg_ack_ev || write_ack_ev));

  // R2
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done_o |-> cpu_busy_o);

  // R6
  neg_not_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done_o && cpu_neg_o |-> !cpu_zero_o);
endmodule

bind swaplock_unit swaplock_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_busy_o   (cpu_busy_o),
  .cpu_done_o   (cpu_done_o),
  .cpu_zero_o   (cpu_zero_o),
  .cpu_neg_o    (cpu_neg_o),
  .mem_valid_o  (mem_valid_o),
  .mem_op_o     (mem_op_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_ready_i  (mem_ready_i),
  .mem_rdata_i  (mem_rdata_i),
  .xchg_ack_ev  (xchg_ack_ev),
  .write_ack_ev (write_ack_ev)
);

// File: tb/swaplock_unit_bench.sv
module swaplock_unit_bench;
  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req_i = 1'b0;
  logic [AW-1:0] cpu_addr_i = '0;
  logic          cpu_busy_o, cpu_done_o, cpu_carry_o, cpu_zero_o, cpu_neg_o;
  logic [DW-1:0] cpu_result_o;
  logic          mem_valid_o;
  logic [1:0]    mem_op_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic          mem_ready_i = 1'b0;
  logic [DW-1:0] mem_rdata_i = '0;

  always #10 clk = ~clk;

  swaplock_unit #(.ADDR_W(AW), .DATA_W(DW)) u_swaplock_unit (.*);

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model
  logic [DW-1:0] mem [0:15];
  int lat_cfg = 0;
  int cnt = 0;
  int xchg_cnt = 0;
  int write_cnt = 0;
  logic [1:0]    cur_op;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;

  always @(negedge clk) begin
    if (mem_ready_i) begin
      mem[cur_addr[3:0]] = cur_wdata;
      if (cur_op == 2'd1) xchg_cnt++;
      if (cur_op == 2'd2) write_cnt++;
      mem_ready_i = 1'b0;
      cnt = 0;
    end else if (mem_valid_o) begin
      if (cnt >= lat_cfg) begin
        mem_ready_i = 1'b1;
        mem_rdata_i = mem[mem_addr_o[3:0]];
        cur_op      = mem_op_o;
        cur_addr    = mem_addr_o;
        cur_wdata   = mem_wdata_o;
      end else begin
        cnt++;
      end
    end
  end

  typedef struct {
    logic [AW-1:0] addr;
    logic [DW-1:0] res;
    logic          carry;
    logic          zero;
    logic          neg;
  } exp_t;

  exp_t exp_q[$];
  exp_t pend_e;
  bit   pend = 0;

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend) begin
        check(!cpu_done_o, "R7 done single pulse", cpu_done_o, 0);
        check(mem[pend_e.addr[3:0]] == pend_e.res, "R4 final memory byte",
              mem[pend_e.addr[3:0]], pend_e.res);
        pend = 0;
      end else if (cpu_done_o) begin
        if (exp_q.size() == 0) begin
          check(0, "R8 unexpected done", 1, 0);
        end else begin
          pend_e = exp_q.pop_front();
          pend = 1;
          check(cpu_result_o == pend_e.res, "R3/R4 result", cpu_result_o, pend_e.res);
          check(cpu_carry_o == pend_e.carry, "R5 carry", cpu_carry_o, pend_e.carry);
          check(cpu_zero_o == pend_e.zero, "R6 zero flag", cpu_zero_o, pend_e.zero);
          check(cpu_neg_o == pend_e.neg, "R6 neg flag", cpu_neg_o, pend_e.neg);
        end
      end
    end
  end

  task automatic run_op(input logic [AW-1:0] a, input logic [DW-1:0] v,
                        input int lat, input bit intrude);
    exp_t e;
    int x0, w0, guard;
    bit lockv;
    lockv   = (v == 8'd0) || (v == 8'd1);
    e.addr  = a;
    e.res   = lockv ? 8'd0 : DW'($signed(v) >>> 1);
    e.carry = v[0];
    e.zero  = (e.res == 0);
    e.neg   = e.res[DW-1];
    @(negedge clk);
    mem[a[3:0]] = v;
    lat_cfg = lat;
    x0 = xchg_cnt;
    w0 = write_cnt;
    exp_q.push_back(e);
    cpu_req_i  = 1'b1;
    cpu_addr_i = a;
    @(negedge clk);
    cpu_req_i = 1'b0;
    // R2: exchange request appears one cycle after acceptance
    check(mem_valid_o && mem_op_o == 2'd1, "R2 exchange issued", mem_op_o, 1);
    check(mem_addr_o == a && mem_wdata_o == 0, "R2 exchange addr/data",
          {mem_addr_o, mem_wdata_o}, {a, 8'h00});
    check(cpu_busy_o, "R2 busy during op", cpu_busy_o, 1);
    if (intrude) begin
      mem[9] = 8'd1;
      cpu_req_i  = 1'b1;
      cpu_addr_i = 16'd9;
      @(negedge clk);
      @(negedge clk);
      cpu_req_i = 1'b0;
    end
    guard = 0;
    while (!cpu_done_o && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    @(negedge clk);
    check(xchg_cnt - x0 == 1, "R8 one exchange per op", xchg_cnt - x0, 1);
    if (lockv)
      check(write_cnt == w0, "R3 no write for lock value", write_cnt - w0, 0);
    else
      check(write_cnt - w0 == 1, "R4 one write for data value", write_cnt - w0, 1);
    if (intrude)
      check(mem[9] == 8'd1, "R8 busy request ignored", mem[9], 1);
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!cpu_busy_o && !cpu_done_o && !mem_valid_o, "R1 reset state",
          {cpu_busy_o, cpu_done_o, mem_valid_o}, 0);
    run_op(16'd1, 8'h01, 0, 0);
    run_op(16'd2, 8'h00, 2, 0);
    run_op(16'd3, 8'h02, 0, 0);
    run_op(16'd4, 8'h03, 3, 0);
    run_op(16'd5, 8'h80, 1, 0);
    run_op(16'd6, 8'hFF, 2, 0);
    run_op(16'd7, 8'h7F, 0, 0);
    run_op(16'd8, 8'hFE, 1, 0);
    run_op(16'd10, 8'h55, 3, 0);
    run_op(16'd11, 8'h01, 3, 1);
    run_op(16'd12, 8'hA4, 3, 1);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R7 every op completed", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule